// File: doc/BRIEF.md
# Converter Conversion Sequencer

This block is the digital control around a successive-approximation analog-to-digital converter. Software talks to it through two byte-wide registers. The control register holds the enable, the start/busy bit, the trigger-mode enable, the completion flag, the interrupt enable and a 3-bit clock divider select. The select register holds a channel number and a reference choice. The block derives the converter clock from the system clock and times each conversion in converter clocks. At the end of a conversion it captures the 10-bit analog sample, sets the completion flag and raises an interrupt request.

A conversion can start in two ways: software writes the start bit, or a rising edge arrives on the trigger input while trigger mode is on. The first conversion after the block is enabled is longer, because it also initialises the converter. Any change to the channel or reference made while a conversion is running is held back until that conversion ends, so each conversion uses the selection that was in force when it began.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `ctrl_rd` reads 0x00, `flag`, `irq` and `done` are low, and `ch_sel` and `ref_sel` are 0.
- R2: Control register (`wr_addr`=0) layout: bit7 enable, bit6 start/busy, bit5 trigger mode, bit4 flag, bit3 interrupt enable, bits 2:0 divider select. The divider select maps 0 and 1 to a divide-by-2, and any other value s to a divide-by-2^s. A conversion of N converter clocks keeps busy high for exactly N×D system cycles, counted from the clock edge that accepts the start, where D is the divide factor.
- R3: The first conversion started after enable goes from 0 to 1 lasts 25 converter clocks. This includes a start written in the same cycle as the enable. Every later conversion lasts 13.
- R4: Bit 6 of `ctrl_rd` reads 1 exactly while a conversion is in progress. Writing 1 to it while idle and enabled starts a conversion. Writing 0 to it, or writing 1 while busy, has no effect on the conversion in progress.
- R5: Writing the control register with enable 0 during a conversion aborts it. Busy is low from the next cycle. No done pulse follows, and the flag and `result` are unchanged.
- R6: With trigger mode and enable set, a rising edge on `trig_in` starts a conversion. Edges that arrive while busy are ignored, and with trigger mode off an edge starts nothing.
- R7: At the end of a conversion, `result` takes the value of `ana_value`. `done` pulses high for one cycle, the flag sets, and busy falls, all on the same clock edge.
- R8: Writing 1 to bit 4 of the control register clears the flag, and writing 0 leaves it unchanged. If a clearing write lands on the same edge as a completion, the flag stays set.
- R9: A one-cycle `irq_ack` pulse clears the flag.
- R10: `irq` is high exactly when the flag, the interrupt enable and `gie` are all high.
- R11: Select register (`wr_addr`=1) layout: bits 4:3 reference, bits 2:0 channel. `mux_rd` returns the written byte. While idle, `ch_sel` and `ref_sel` follow a write on the next cycle. A write made during a conversion reaches them only on the edge where that conversion ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the control register, 1 selects the select register |
| wr_data | input | 8 | Write data |
| trig_in | input | 1 | External conversion trigger |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| ana_value | input | 10 | Modelled analog sample |
| ctrl_rd | output | 8 | Control register readback (bit 6 = busy) |
| mux_rd | output | 8 | Select register readback |
| ch_sel | output | 3 | Channel in effect |
| ref_sel | output | 2 | Reference in effect |
| result | output | 10 | Last conversion result |
| done | output | 1 | One-cycle completion pulse to the result block |
| irq | output | 1 | Interrupt request |

## Verification
A start accepted on edge E0 raises busy right after E0. It drops together with the rise of `done` and the flag on edge E0+N×D. An abort takes effect on the edge that samples the write, and select writes reach `ch_sel`/`ref_sel` one edge after an idle write or on the completion edge. Inputs are driven and outputs sampled at the falling edge. Each scenario counts falling edges from the accepting edge, so each check lands in the last busy cycle, the completion cycle and the cycle after it. `irq` is combinational, so it is checked in the same half-cycle in which `gie` changes.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
    // Control byte bit positions, decoded by software
    localparam int CTRL_EN   = 7;
    localparam int CTRL_GO   = 6;
    localparam int CTRL_AUTO = 5;
    localparam int CTRL_FLAG = 4;
    localparam int CTRL_IE   = 3;

    // Divide factor for a divider select code
    function automatic int unsigned div_factor(input int unsigned sel);
        return (sel < 2) ? 2 : (32'd1 << sel);
    endfunction
endpackage

// File: rtl/adc_clk_div.sv
`timescale 1ns/1ps
module adc_clk_div #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [PS_W-1:0] ps_sel,
    output logic            tick
);
    import adc_seq_pkg::*;

    localparam int CNT_W = (2 ** PS_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_st_t;

    div_st_t s_d, s_q;
    logic [CNT_W:0] div_w;

    always_comb begin
        div_w = (CNT_W+1)'(div_factor(32'(ps_sel)));
        tick  = run && ({1'b0, s_q.cnt} >= (div_w - 1'b1));
        s_d   = s_q;
        if (!run || tick) s_d.cnt = '0;
        else              s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R2
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tick) |-> s_q.cnt == '0);
endmodule

// File: rtl/adc_conv_timer.sv
`timescale 1ns/1ps
module adc_conv_timer #(
    parameter int LEN_LONG  = 25,
    parameter int LEN_SHORT = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic long_sel,
    input  logic abort,
    input  logic tick,
    output logic busy,
    output logic finish
);
    localparam int CYC_W = $clog2(LEN_LONG + 1);

    typedef struct packed {
        logic             busy;
        logic             long_q;
        logic [CYC_W-1:0] cyc;
    } tmr_st_t;

    tmr_st_t s_d, s_q;
    logic [CYC_W-1:0] len;

    always_comb begin
        len    = s_q.long_q ? CYC_W'(LEN_LONG) : CYC_W'(LEN_SHORT);
        finish = s_q.busy && tick && (s_q.cyc == len - 1'b1);
        s_d    = s_q;
        if (abort) begin
            s_d.busy = 1'b0;
            s_d.cyc  = '0;
        end else if (start && !s_q.busy) begin
            s_d.busy   = 1'b1;
            s_d.cyc    = '0;
            s_d.long_q = long_sel;
        end else if (s_q.busy && tick) begin
            if (finish) begin
                s_d.busy = 1'b0;
                s_d.cyc  = '0;
            end else begin
                s_d.cyc = s_q.cyc + 1'b1;
            end
        end
    end

    assign busy = s_q.busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3
    cyc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> s_q.cyc < len);
endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl #(
    parameter int RES_W     = 10,
    parameter int CH_W      = 3,
    parameter int REF_W     = 2,
    parameter int PS_W      = 3,
    parameter int LEN_LONG  = 25,
    parameter int LEN_SHORT = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [7:0]       wr_data,
    input  logic             trig_in,
    input  logic             gie,
    input  logic             irq_ack,
    input  logic [RES_W-1:0] ana_value,
    output logic [7:0]       ctrl_rd,
    output logic [7:0]       mux_rd,
    output logic [CH_W-1:0]  ch_sel,
    output logic [REF_W-1:0] ref_sel,
    output logic [RES_W-1:0] result,
    output logic             done,
    output logic             irq
);
    import adc_seq_pkg::*;

    localparam int SEL_HI = CH_W + REF_W - 1;

    typedef struct packed {
        logic             en;
        logic             auto_q;
        logic             ie;
        logic [PS_W-1:0]  ps;
        logic             flag;
        logic             first;
        logic             trig;
        logic             done;
        logic [RES_W-1:0] res;
        logic [7:0]       pend;
        logic [CH_W-1:0]  act_ch;
        logic [REF_W-1:0] act_ref;
    } seq_st_t;

    seq_st_t s_d, s_q;

    logic ctrl_wr, sel_wr, abort, start, long_sel, trig_edge, busy_nx;
    logic busy, finish, tick;

    adc_clk_div #(.PS_W(PS_W)) div_i (
        .clk(clk), .rst_n(rst_n), .run(busy), .ps_sel(s_q.ps), .tick(tick)
    );

    adc_conv_timer #(.LEN_LONG(LEN_LONG), .LEN_SHORT(LEN_SHORT)) tmr_i (
        .clk(clk), .rst_n(rst_n), .start(start), .long_sel(long_sel),
        .abort(abort), .tick(tick), .busy(busy), .finish(finish)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.trig = trig_in;
        ctrl_wr  = wr_en && !wr_addr;
        sel_wr   = wr_en && wr_addr;

        if (ctrl_wr) begin
            s_d.en     = wr_data[CTRL_EN];
            s_d.auto_q = wr_data[CTRL_AUTO];
            s_d.ie     = wr_data[CTRL_IE];
            s_d.ps     = wr_data[PS_W-1:0];
            if (!s_q.en && wr_data[CTRL_EN]) s_d.first = 1'b1;
        end
        if (sel_wr) s_d.pend = wr_data;

        abort     = busy && ctrl_wr && !wr_data[CTRL_EN];
        trig_edge = trig_in && !s_q.trig;
        start     = !busy && s_d.en &&
                    ((ctrl_wr && wr_data[CTRL_GO]) ||
                     (s_q.en && s_q.auto_q && trig_edge));
        long_sel  = s_d.first;
        if (start) s_d.first = 1'b0;

        if ((ctrl_wr && wr_data[CTRL_FLAG]) || irq_ack) s_d.flag = 1'b0;
        if (finish) begin
            s_d.flag = 1'b1;
            s_d.done = 1'b1;
            s_d.res  = ana_value;
        end

        busy_nx = start || (busy && !abort && !finish);
        if (!busy_nx) begin
            s_d.act_ch  = s_d.pend[CH_W-1:0];
            s_d.act_ref = s_d.pend[SEL_HI:CH_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctrl_rd = {s_q.en, busy, s_q.auto_q, s_q.flag, s_q.ie, s_q.ps};
    assign mux_rd  = s_q.pend;
    assign ch_sel  = s_q.act_ch;
    assign ref_sel = s_q.act_ref;
    assign result  = s_q.res;
    assign done    = s_q.done;
    assign irq     = s_q.flag && s_q.ie && gie;

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> !busy);
    // R7
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.flag) |-> s_q.done);
    // R11
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(s_q.act_ch) && $stable(s_q.act_ref)));
    // R5
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && $past(wr_en) && !$past(wr_addr) && !$past(wr_data[CTRL_EN]))
        |-> (!busy && !s_q.done));
endmodule

// File: tb/adc_seq_ctrl_tb.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_addr = 1'b0;
    logic [7:0] wr_data = '0;
    logic       trig_in = 1'b0, gie = 1'b0, irq_ack = 1'b0;
    logic [9:0] ana_value = '0;
    logic [7:0] ctrl_rd, mux_rd;
    logic [2:0] ch_sel;
    logic [1:0] ref_sel;
    logic [9:0] result;
    logic       done, irq;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    adc_seq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .trig_in(trig_in), .gie(gie), .irq_ack(irq_ack),
        .ana_value(ana_value), .ctrl_rd(ctrl_rd), .mux_rd(mux_rd),
        .ch_sel(ch_sel), .ref_sel(ref_sel), .result(result), .done(done),
        .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; the write is sampled by the next rising edge
    task automatic wr(input logic a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    // left = system cycles from the start edge still to run, counted from now
    task automatic finish_conv(input int left, input logic [9:0] exp_res);
        repeat (left - 1) @(negedge clk);
        chk("R2 busy in last cycle", 32'(ctrl_rd[6]), 1);
        chk("R7 no done before end", 32'(done), 0);
        @(negedge clk);
        chk("R7 busy falls at end", 32'(ctrl_rd[6]), 0);
        chk("R7 done at end", 32'(done), 1);
        chk("R7 flag set at end", 32'(ctrl_rd[4]), 1);
        chk("R7 result captured", 32'(result), 32'(exp_res));
        @(negedge clk);
        chk("R7 done one cycle", 32'(done), 0);
    endtask

    task automatic t_reset();
        chk("R1 ctrl reset", 32'(ctrl_rd), 0);
        chk("R1 done reset", 32'(done), 0);
        chk("R1 irq reset", 32'(irq), 0);
        chk("R1 ch reset", 32'(ch_sel), 0);
        chk("R1 ref reset", 32'(ref_sel), 0);
    endtask

    task automatic t_first_long();
        ana_value = 10'h2A5;
        wr(0, 8'hC0);
        chk("R4 busy reads one", 32'(ctrl_rd[6]), 1);
        finish_conv(25 * 2, 10'h2A5);   // R3 first conversion 25 clocks
    endtask

    task automatic t_short();
        ana_value = 10'h15A;
        wr(0, 8'hC1);
        chk("R8 zero write keeps flag", 32'(ctrl_rd[4]), 1);
        finish_conv(13 * 2, 10'h15A);   // R3 later conversion 13 clocks
    endtask

    task automatic t_presc();
        wr(0, 8'h90);
        chk("R8 one write clears flag", 32'(ctrl_rd[4]), 0);
        ana_value = 10'h001; wr(0, 8'hC2); finish_conv(13 * 4, 10'h001);   // R2 div 4
        ana_value = 10'h3FF; wr(0, 8'hC3); finish_conv(13 * 8, 10'h3FF);   // R2 div 8
        ana_value = 10'h0F0; wr(0, 8'hC7); finish_conv(13 * 128, 10'h0F0); // R2 div 128
    endtask

    task automatic t_go_ignored();
        ana_value = 10'h123;
        wr(0, 8'hC1);
        wr(0, 8'h81);
        chk("R4 zero to start keeps busy", 32'(ctrl_rd[6]), 1);
        wr(0, 8'hC1);
        finish_conv(26 - 2, 10'h123);   // R4 restart while busy ignored
    endtask

    task automatic t_abort();
        wr(0, 8'h91);
        ana_value = 10'h055;
        wr(0, 8'hC1);
        repeat (5) @(negedge clk);
        wr(0, 8'h01);
        chk("R5 abort drops busy", 32'(ctrl_rd[6]), 0);
        chk("R5 abort no done", 32'(done), 0);
        chk("R5 abort flag kept", 32'(ctrl_rd[4]), 0);
        chk("R5 abort result kept", 32'(result), 32'h123);
        repeat (60) @(negedge clk);
        chk("R5 no late done", 32'(ctrl_rd[4]), 0);
        ana_value = 10'h2BC;
        wr(0, 8'hC1);
        finish_conv(25 * 2, 10'h2BC);   // R3 enable and start together
    endtask

    task automatic t_collide();
        wr(0, 8'h91);
        ana_value = 10'h0AA;
        wr(0, 8'hC1);
        repeat (25) @(negedge clk);
        wr(0, 8'h91);
        chk("R8 set wins over clear", 32'(ctrl_rd[4]), 1);
        chk("R7 done on collide", 32'(done), 1);
    endtask

    task automatic t_irq();
        chk("R10 no irq without enable", 32'(irq), 0);
        gie = 1'b1;
        wr(0, 8'h89);
        chk("R10 irq asserted", 32'(irq), 1);
        gie = 1'b0; #1;
        chk("R10 irq masked by gie", 32'(irq), 0);
        gie = 1'b1; #1;
        chk("R10 irq back", 32'(irq), 1);
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        chk("R9 ack clears flag", 32'(ctrl_rd[4]), 0);
        chk("R9 ack drops irq", 32'(irq), 0);
    endtask

    task automatic t_auto();
        wr(0, 8'hA1);
        ana_value = 10'h1E1;
        trig_in = 1'b1;
        @(negedge clk);
        chk("R6 edge starts", 32'(ctrl_rd[6]), 1);
        trig_in = 1'b0;
        @(negedge clk);
        trig_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0;
        finish_conv(26 - 2, 10'h1E1);
        chk("R6 busy edge ignored", 32'(ctrl_rd[6]), 0);
        wr(0, 8'h81);
        trig_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R6 no start with mode off", 32'(ctrl_rd[6]), 0);
        trig_in = 1'b0;
    endtask

    task automatic t_sel();
        wr(1, 8'h1D);
        chk("R11 idle ch follows", 32'(ch_sel), 5);
        chk("R11 idle ref follows", 32'(ref_sel), 3);
        ana_value = 10'h321;
        wr(0, 8'hC1);
        wr(1, 8'h0A);
        chk("R11 readback immediate", 32'(mux_rd), 32'h0A);
        chk("R11 ch held while busy", 32'(ch_sel), 5);
        chk("R11 ref held while busy", 32'(ref_sel), 3);
        finish_conv(26 - 1, 10'h321);
        chk("R11 ch after end", 32'(ch_sel), 2);
        chk("R11 ref after end", 32'(ref_sel), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_long();
        t_short();
        t_presc();
        t_go_ignored();
        t_abort();
        t_collide();
        t_irq();
        t_auto();
        t_sel();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule